// File: doc/BRIEF.md
# Buffered UART Transmitter

This block is the transmit half of a UART. A host writes one byte at a time into a single-byte holding buffer. As soon as the shift register is idle, the buffered byte moves into it and an interrupt request tells the host that the buffer is free again. The host can then queue the next byte while the current character is still on the line.

Each character is sent as a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. Four static configuration inputs select 7 or 8 data bits, the stop-bit count, and whether parity is used and of which sense. The configuration is taken when a byte enters the shift register. Bit timing comes from an external baud tick enable, and every bit lasts a fixed number of ticks.

Top module: `uart_tx_buf`

## Requirements
- R1: After reset, `txd` is 1 and `busy`, `irq` and `ovf_err` are 0.
- R2: A frame begins with one start bit at 0. The data bits follow, least significant first, and each bit lasts `TICKS_PER_BIT` (16) cycles in which `baud_tick` is high. The line is 1 whenever no frame is being sent.
- R3: With `cfg_len8`=1, eight data bits are sent. With `cfg_len8`=0, seven bits are sent (`wr_data[6:0]`) and `wr_data[7]` is dropped. The configuration is taken at the moment the byte enters the shift register.
- R4: With `cfg_par_en`=1, one parity bit follows the last data bit. With `cfg_par_even`=1, the data bits plus the parity bit hold an even number of ones. With `cfg_par_even`=0, they hold an odd number of ones.
- R5: With `cfg_par_en`=0, no parity bit is sent and `cfg_par_even` has no effect on the frame.
- R6: After the data bits and any parity bit, the frame ends with two stop bits at 1 when `cfg_stop2`=1, and one stop bit when `cfg_stop2`=0.
- R7: `busy` is 1 from the start bit to the end of the last stop bit, and returns to 0 on the final tick of that stop bit.
- R8: A byte written while the buffer is empty enters the shift register on the next idle cycle of the shifter. It is sent immediately after any frame in progress. `irq` rises in the cycle of that transfer.
- R9: `irq` stays at 1 until the next accepted write or until a pulse on `irq_clr`.
- R10: A write while the buffer already holds a byte is ignored: the held byte is sent unchanged and no extra frame appears. `ovf_err` is set and remains set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Bit-timing enable, one per sub-bit period |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| cfg_par_en | input | 1 | 1: append parity bit |
| cfg_par_even | input | 1 | 1: even parity, 0: odd parity |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to transmit |
| irq_clr | input | 1 | Clears the buffer-empty request |
| txd | output | 1 | Serial output |
| busy | output | 1 | Frame in progress |
| irq | output | 1 | Buffer-empty interrupt request |
| ovf_err | output | 1 | Sticky write-while-full flag |

## Verification
A write captured at clock edge W fills the buffer. If the shifter is idle, the byte transfers at edge W+1: `irq` and `busy` are 1 from that edge on, and the start bit appears on `txd` at the same time. The bench samples every output on the falling clock edge, so it reads the state one half period after each rising edge. A monitor detects the start bit and samples each bit at its midpoint, which is half a bit period and then one bit period per bit after detection. It then checks `busy` just after the edge that ends the last stop bit. Expected frames for all 16 configurations are computed by arithmetic in the bench and compared in full, with the back-to-back, overflow and slow-tick cases run on top.

// File: rtl/uart_tx_buf.sv
module uart_tx_buf #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       cfg_len8,
  input  logic       cfg_stop2,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       irq_clr,
  output logic       txd,
  output logic       busy,
  output logic       irq,
  output logic       ovf_err
);
  localparam int TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int FW = 12;

  logic          full, active;
  logic [7:0]    hold;
  logic [FW-1:0] sr;
  logic [3:0]    nbits, bitcnt;
  logic [TW-1:0] tcnt;

  function automatic logic [FW-1:0] build(input logic [7:0] d, input logic len8,
                                          input logic pen, input logic even);
    logic [FW-1:0] f;
    logic [7:0]    dm;
    logic          p;
    dm = len8 ? d : {1'b0, d[6:0]};
    p  = (^dm) ^ ~even;
    f  = '1;
    f[0] = 1'b0;
    if (len8) begin
      f[8:1] = dm;
      if (pen) f[9] = p;
    end else begin
      f[7:1] = dm[6:0];
      if (pen) f[8] = p;
    end
    return f;
  endfunction

  wire accept    = wr_en && !full;
  wire load      = full && !active;
  wire bit_end   = active && baud_tick && (tcnt == TW'(TICKS_PER_BIT - 1));
  wire frame_end = bit_end && (bitcnt == nbits - 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full    <= 1'b0;
      hold    <= '0;
      active  <= 1'b0;
      sr      <= '1;
      nbits   <= '0;
      bitcnt  <= '0;
      tcnt    <= '0;
      irq     <= 1'b0;
      ovf_err <= 1'b0;
    end else begin
      if (accept) begin
        full <= 1'b1;
        hold <= wr_data;
      end else if (load) begin
        full <= 1'b0;
      end
      if (wr_en && full) ovf_err <= 1'b1;
      if (load) irq <= 1'b1;
      else if (accept || irq_clr) irq <= 1'b0;
      if (load) begin
        active <= 1'b1;
        sr     <= build(hold, cfg_len8, cfg_par_en, cfg_par_even);
        nbits  <= 4'd9 + {3'b0, cfg_len8} + {3'b0, cfg_par_en} + {3'b0, cfg_stop2};
        bitcnt <= '0;
        tcnt   <= '0;
      end else if (active && baud_tick) begin
        if (bit_end) begin
          tcnt   <= '0;
          sr     <= {1'b1, sr[FW-1:1]};
          bitcnt <= bitcnt + 4'd1;
          if (frame_end) active <= 1'b0;
        end else begin
          tcnt <= tcnt + TW'(1);
        end
      end
    end
  end

  assign txd  = active ? sr[0] : 1'b1;
  assign busy = active;

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && !$past(baud_tick)) |-> $stable(txd));
  p_end_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(baud_tick));
  p_irq_on_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $rose(busy));
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq) && !$past(wr_en) && !$past(irq_clr)) |-> irq);
  p_ovf_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_err) |-> ($past(wr_en) && $past(full)));
endmodule

// File: tb/uart_tx_buf_test.sv
module uart_tx_buf_test;
  logic clk = 0, rst_n = 0, baud_tick = 0;
  logic cfg_len8 = 0, cfg_stop2 = 0, cfg_par_en = 0, cfg_par_even = 0;
  logic wr_en = 0, irq_clr = 0;
  logic [7:0] wr_data = 0;
  logic txd, busy, irq, ovf_err;

  int vectors = 0, errors = 0;
  int tick_div = 1;
  int ncap = 0;
  logic [11:0] cap [0:255];

  uart_tx_buf uut (.*);

  always #10 clk = ~clk;

  initial begin : tickgen
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      c++;
      baud_tick = (c % tick_div) == 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] expect_frame(input logic [7:0] d, input logic l8,
                                               input logic st2, input logic pe, input logic ev);
    int n, ones;
    logic [11:0] f;
    n = l8 ? 8 : 7;
    ones = 0;
    f = 12'hFFF;
    f[0] = 0;
    for (int i = 0; i < n; i++) begin
      f[i+1] = d[i];
      ones += int'(d[i]);
    end
    if (pe) f[n+1] = ((ones % 2) == 1) == ev;
    return f;
  endfunction

  initial begin : monitor
    int nb, bc;
    logic [11:0] w;
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        nb = 1 + (cfg_len8 ? 8 : 7) + int'(cfg_par_en) + (cfg_stop2 ? 2 : 1);
        bc = 16 * tick_div;
        w = 12'hFFF;
        repeat (bc / 2) @(negedge clk);
        for (int b = 0; b < nb; b++) begin
          if (b > 0) repeat (bc) @(negedge clk);
          w[b] = txd;
        end
        check("R7 busy in last stop bit", 32'(busy), 1);
        repeat (bc / 2) @(negedge clk);
        if (tick_div == 1) check("R7 busy low after last stop", 32'(busy), 0);
        cap[ncap] = w;
        ncap++;
      end
    end
  end

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1;
    wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_frames(input int target);
    while (ncap < target) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin : main
    logic [11:0] e1, e2;
    int base;
    repeat (3) @(negedge clk);
    check("R1 txd idle", 32'(txd), 1);
    check("R1 busy", 32'(busy), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 ovf_err", 32'(ovf_err), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R2 line idle high", 32'(txd), 1);

    for (int c = 0; c < 16; c++) begin
      cfg_len8 = c[0]; cfg_stop2 = c[1]; cfg_par_en = c[2]; cfg_par_even = c[3];
      for (int k = 0; k < 4; k++) begin
        logic [7:0] d;
        d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(c * 29 + k * 83 + 5);
        base = ncap;
        write_byte(d);
        wait_frames(base + 1);
        check($sformatf("R2 R3 R4 R5 R6 frame cfg=%0d d=%0h", c, d), 32'(cap[base]),
              32'(expect_frame(d, c[0], c[1], c[2], c[3])));
      end
    end

    repeat (20) @(negedge clk);
    cfg_len8 = 1; cfg_stop2 = 0; cfg_par_en = 1; cfg_par_even = 1;
    base = ncap;
    write_byte(8'h3C);
    check("R8 buffer not moved yet", 32'(busy), 0);
    @(negedge clk);
    check("R8 transfer next cycle busy", 32'(busy), 1);
    check("R8 irq on transfer", 32'(irq), 1);
    check("R2 start bit", 32'(txd), 0);
    repeat (5) @(negedge clk);
    check("R9 irq holds", 32'(irq), 1);
    write_byte(8'hC5);
    check("R9 irq cleared by write", 32'(irq), 0);
    write_byte(8'h77);
    check("R10 ovf_err set", 32'(ovf_err), 1);
    wait_frames(base + 1);
    repeat (16) @(negedge clk);
    check("R8 second byte loaded irq", 32'(irq), 1);
    check("R8 second byte busy", 32'(busy), 1);
    @(negedge clk);
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
    check("R9 irq cleared by strobe", 32'(irq), 0);
    wait_frames(base + 2);
    e1 = expect_frame(8'h3C, 1, 0, 1, 1);
    e2 = expect_frame(8'hC5, 1, 0, 1, 1);
    check("R8 first frame", 32'(cap[base]), 32'(e1));
    check("R10 held byte unchanged", 32'(cap[base+1]), 32'(e2));
    repeat (400) @(negedge clk);
    check("R10 no extra frame", 32'(ncap), 32'(base + 2));
    check("R10 ovf_err sticky", 32'(ovf_err), 1);

    tick_div = 3;
    cfg_len8 = 0; cfg_stop2 = 1; cfg_par_en = 1; cfg_par_even = 0;
    repeat (10) @(negedge clk);
    base = ncap;
    write_byte(8'hB3);
    wait_frames(base + 1);
    check("R2 slow tick frame", 32'(cap[base]), 32'(expect_frame(8'hB3, 0, 1, 1, 0)));
    repeat (100) @(negedge clk);
    check("R7 idle after slow frame", 32'(busy), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule